// File: doc/BRIEF.md
# Burst CRC Address Sequencer

This block walks a memory built from 128-bit words and feeds every word it reads to a checksum step. A scan covers either one contiguous address window or a chosen subset of four equal sectors. Reads go out in aligned bursts of 4, 16, 64 or 256 words. The block keeps a 32-bit running result. A stand-in step function takes the place of a real polynomial datapath. The same word is also presented on a step port, so an external engine can be attached.

Software controls the block through a write-only register port with four registers: enable, configuration, window start and window end. It watches `busy`, the end flag, the read-error flag and the result, which come out as plain outputs. Memory is reached over a request/response port that has one read outstanding at a time. Configuration is captured when a scan starts, so changes made during a scan cannot disturb it.

Top module: `crc_burst_scanner`

## Requirements
- R1: After reset, `busy`, `endFlag`, `errFlag`, `memReq` and `result` are all zero.
- R2: Configuration bits [4:3] hold a burst code. Code 0, 1, 2 and 3 select bursts of 4, 16, 64 and 256 words, which is 64, 256, 1024 and 4096 bytes. Every burst starts on a multiple of its own size. Successive reads step up by 16 bytes, and this also holds across burst boundaries.
- R3: Range mode is selected when configuration bit 2 is 0. The window start sits in bits [16:6] of register 2 and the window end in bits [16:6] of register 3; address bits [5:0] are taken as zero. Both values are rounded down to the burst size. The scan runs from the rounded start through the burst that begins at the rounded end. If the end is below the start, exactly one burst is read.
- R4: Sector mode is selected when configuration bit 2 is 1. Sector s spans bytes s·32768 up to s·32768+32767. Writing a configuration word with bit 0 set adds the sector numbered in bits [17:16] to the list. Listed sectors are scanned whole, each once, in ascending order. If the list is empty, the scan ends with no reads one cycle after `busy` rises.
- R5: Configuration bit 1 empties the sector list. When the same write also sets bit 0, the list is emptied first and then holds only the named sector.
- R6: Configuration bit 5 is a set-only request to scan all four sectors. It is cleared when a scan begins, so the following scan uses the stored list again. The list itself is not changed by this bit.
- R7: Configuration bit 6 launches exactly one scan per write. That scan uses the other fields of the same write. The bit is ignored while a scan is running and while the block is disabled.
- R8: `busy` is high from the clock edge that accepts a start until the scan completes. `endFlag` rises when `busy` falls at normal completion. It stays set until a write with configuration bit 8 set, or until the next start, clears it together with `errFlag`. At most one read is outstanding at a time.
- R9: Each word read that is not protected updates the result as `result = rotl1(result) ^ w[31:0] ^ w[63:32] ^ w[95:64] ^ w[127:96]`. A protected word (`rspProt` high) is left out of the result and sets `errFlag`.
- R10: Configuration bit 7 zeroes the result, even while a scan is running. If it arrives in the same cycle as a word update, the clear wins and that word is lost.
- R11: Writing 0 to bit 0 of register 0 disables the block. This zeroes the result, empties the sector list and resets the range fields, the burst code and the mode. A running scan is aborted without setting `endFlag`.
- R12: Writes to the configuration, window-start and window-end registers are ignored while a scan runs and while the block is disabled. The only exceptions are the clear bits 7 and 8, which still act while a scan runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 enable, 1 configuration, 2 window start, 3 window end |
| regWrData | input | 32 | Register write data |
| memReq | output | 1 | Read request, one cycle per word |
| memAddr | output | 17 | Byte address of the requested word (bits [3:0] zero) |
| rspValid | input | 1 | Read data valid |
| rspData | input | 128 | Read data word |
| rspProt | input | 1 | The word returned is protected |
| stepValid | output | 1 | A word is folded into the result this cycle |
| stepWord | output | 128 | The word being folded |
| busy | output | 1 | Scan in progress |
| endFlag | output | 1 | The last scan completed |
| errFlag | output | 1 | A protected word was met during the scan |
| result | output | 32 | Running result |

## Verification
A clear-result write and a word update can fall on the same clock edge. The bench provokes this by waiting until the third request of an eight-word window is on the port, then putting the clear write on the bus for the following cycle, which is the one in which that word returns. The final result is then judged against a fold, starting from zero, of only the words after that one. A sector-list clean and add in one write form a second such pair; that case is judged by the count and the first and last addresses of the following scan.

// File: rtl/crc_scan_pkg.sv
package crc_scan_pkg;

  localparam logic [1:0] SEL_CTL = 2'd0;
  localparam logic [1:0] SEL_CFG = 2'd1;
  localparam logic [1:0] SEL_SA  = 2'd2;
  localparam logic [1:0] SEL_EA  = 2'd3;

  localparam int CFG_ADD     = 0;
  localparam int CFG_CLEAN   = 1;
  localparam int CFG_BYSECT  = 2;
  localparam int CFG_CODE    = 3;
  localparam int CFG_ALL     = 5;
  localparam int CFG_START   = 6;
  localparam int CFG_CLRRES  = 7;
  localparam int CFG_CLRFLG  = 8;
  localparam int CFG_SECT    = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEL   = 2'd1,
    ST_ISSUE = 2'd2,
    ST_WAIT  = 2'd3
  } scanState_t;

  typedef struct packed {
    logic loadSeg;
    logic advance;
    logic fold;
    logic clearRes;
  } dpStrobe_t;

  function automatic logic [31:0] burstBytesOf(input logic [1:0] code, input int minLg);
    return 32'd1 << (minLg + 2 * int'(code));
  endfunction

endpackage

// File: rtl/crc_scan_dp.sv
module crc_scan_dp
  import crc_scan_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int WORD_W       = 128,
  parameter int RES_W        = 32,
  parameter int MIN_BURST_LG = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] segBase,
  input  logic [ADDR_W-1:0] segLast,
  input  logic [1:0]        scanCode,
  input  logic [WORD_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              burstEnd,
  output logic              segEnd,
  output logic [RES_W-1:0]  result,
  output logic              stepValid,
  output logic [WORD_W-1:0] stepWord
);

  localparam int WORD_LG    = $clog2(WORD_W / 8);
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int BW_LG0     = MIN_BURST_LG - WORD_LG;
  localparam int IDX_W      = BW_LG0 + 6;
  localparam int LANES      = WORD_W / RES_W;

  logic [ADDR_W-1:0] burstBase;
  logic [ADDR_W-1:0] segLastQ;
  logic [IDX_W-1:0]  wordIdx;
  logic [IDX_W-1:0]  wordLast;
  logic [ADDR_W-1:0] burstBytes;
  logic [RES_W-1:0]  folded;

  assign burstBytes = ADDR_W'(burstBytesOf(scanCode, MIN_BURST_LG));
  assign wordLast   = IDX_W'((32'd1 << (BW_LG0 + 2 * int'(scanCode))) - 32'd1);
  assign memAddr    = burstBase + (ADDR_W'(wordIdx) << WORD_LG);
  assign burstEnd   = (wordIdx == wordLast);
  assign segEnd     = (burstBase >= segLastQ);

  always_comb begin
    folded = {result[RES_W-2:0], result[RES_W-1]};
    for (int i = 0; i < LANES; i++) begin
      folded = folded ^ rspData[i*RES_W +: RES_W];
    end
  end

  assign stepValid = strb.fold;
  assign stepWord  = rspData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstBase <= '0;
      segLastQ  <= '0;
      wordIdx   <= '0;
    end else if (strb.loadSeg) begin
      burstBase <= segBase;
      segLastQ  <= segLast;
      wordIdx   <= '0;
    end else if (strb.advance) begin
      if (burstEnd) begin
        wordIdx   <= '0;
        burstBase <= burstBase + burstBytes;
      end else begin
        wordIdx <= wordIdx + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
    end else if (strb.clearRes) begin
      result <= '0;
    end else if (strb.fold) begin
      result <= folded;
    end
  end

  // R3: a freshly loaded segment starts on a burst boundary
  assert_load_aligned_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadSeg |=> ((burstBase & (burstBytes - ADDR_W'(1))) == '0));

  // R2: each advance moves the read address up by one word
  assert_word_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance && !strb.loadSeg |=> memAddr == $past(memAddr) + ADDR_W'(WORD_BYTES));

endmodule

// File: rtl/crc_scan_ctrl.sv
module crc_scan_ctrl
  import crc_scan_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int FLD_LSB      = 6,
  parameter int SECT_CNT     = 4,
  parameter int SECT_AW      = 15,
  parameter int MIN_BURST_LG = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [31:0]       regWrData,
  input  logic              rspValid,
  input  logic              rspProt,
  input  logic              burstEnd,
  input  logic              segEnd,
  output dpStrobe_t         strb,
  output logic [ADDR_W-1:0] segBase,
  output logic [ADDR_W-1:0] segLast,
  output logic [1:0]        scanCode,
  output logic              memReq,
  output logic              busy,
  output logic              endFlag,
  output logic              errFlag
);

  localparam int SECT_W = (SECT_CNT > 1) ? $clog2(SECT_CNT) : 1;
  localparam int FLD_W  = ADDR_W - FLD_LSB;

  scanState_t         state;
  logic               enReg;
  logic               bySect;
  logic [1:0]         burstCode;
  logic               allSect;
  logic [SECT_CNT-1:0] sectList;
  logic [FLD_W-1:0]   saFld;
  logic [FLD_W-1:0]   eaFld;
  logic               scanBySect;
  logic [SECT_CNT-1:0] scanMask;
  logic               endQ;
  logic               errQ;

  logic cfgWr, takeCfg, startFire, disableNow, clrRes, clrFlags, idle;
  logic               bySectNext;
  logic [1:0]         codeNext;
  logic               allNext;
  logic [SECT_CNT-1:0] listAfter;
  logic [SECT_CNT-1:0] addMask;
  logic [SECT_W-1:0]  secIdx;
  logic [ADDR_W-1:0]  secBase, secLast, rangeBase, rangeRaw, rangeLast, codeMask;

  assign idle       = (state == ST_IDLE);
  assign busy       = !idle;
  assign endFlag    = endQ;
  assign errFlag    = errQ;
  assign cfgWr      = regWrEn && (regSel == SEL_CFG);
  assign takeCfg    = cfgWr && enReg && idle;
  assign disableNow = regWrEn && (regSel == SEL_CTL) && !regWrData[0];
  assign clrRes     = disableNow || (cfgWr && enReg && regWrData[CFG_CLRRES]);
  assign clrFlags   = cfgWr && enReg && regWrData[CFG_CLRFLG];
  assign startFire  = takeCfg && regWrData[CFG_START];

  assign addMask    = regWrData[CFG_ADD] ? (SECT_CNT'(1) << regWrData[CFG_SECT +: SECT_W]) : '0;
  assign listAfter  = takeCfg ? ((regWrData[CFG_CLEAN] ? '0 : sectList) | addMask) : sectList;
  assign bySectNext = takeCfg ? regWrData[CFG_BYSECT] : bySect;
  assign codeNext   = takeCfg ? regWrData[CFG_CODE +: 2] : burstCode;
  assign allNext    = allSect | (takeCfg && regWrData[CFG_ALL]);

  // lowest listed sector of the running scan
  always_comb begin
    secIdx = '0;
    for (int i = SECT_CNT - 1; i >= 0; i--) begin
      if (scanMask[i]) secIdx = SECT_W'(i);
    end
  end

  assign secBase   = ADDR_W'(secIdx) << SECT_AW;
  assign secLast   = secBase + (ADDR_W'(1) << SECT_AW)
                   - ADDR_W'(burstBytesOf(scanCode, MIN_BURST_LG));
  assign codeMask  = ADDR_W'(burstBytesOf(codeNext, MIN_BURST_LG)) - ADDR_W'(1);
  assign rangeBase = {saFld, FLD_LSB'(0)} & ~codeMask;
  assign rangeRaw  = {eaFld, FLD_LSB'(0)} & ~codeMask;
  assign rangeLast = (rangeRaw < rangeBase) ? rangeBase : rangeRaw;
  assign segBase   = (state == ST_SEL) ? secBase : rangeBase;
  assign segLast   = (state == ST_SEL) ? secLast : rangeLast;

  always_comb begin
    strb          = '0;
    strb.clearRes = clrRes;
    memReq        = 1'b0;
    case (state)
      ST_IDLE:  strb.loadSeg = startFire && !bySectNext;
      ST_SEL:   strb.loadSeg = |scanMask;
      ST_ISSUE: memReq = 1'b1;
      ST_WAIT: begin
        if (rspValid) begin
          strb.fold    = !rspProt;
          strb.advance = !(burstEnd && segEnd);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      enReg      <= 1'b0;
      bySect     <= 1'b0;
      burstCode  <= '0;
      allSect    <= 1'b0;
      sectList   <= '0;
      saFld      <= '0;
      eaFld      <= '0;
      scanBySect <= 1'b0;
      scanCode   <= '0;
      scanMask   <= '0;
      endQ       <= 1'b0;
      errQ       <= 1'b0;
    end else begin
      if (regWrEn && (regSel == SEL_CTL)) enReg <= regWrData[0];
      if (disableNow) begin
        state     <= ST_IDLE;
        bySect    <= 1'b0;
        burstCode <= '0;
        allSect   <= 1'b0;
        sectList  <= '0;
        saFld     <= '0;
        eaFld     <= '0;
        scanMask  <= '0;
      end else begin
        if (clrFlags) begin
          endQ <= 1'b0;
          errQ <= 1'b0;
        end
        if (takeCfg) begin
          bySect    <= bySectNext;
          burstCode <= codeNext;
          allSect   <= allNext;
          sectList  <= listAfter;
        end
        if (regWrEn && enReg && idle && (regSel == SEL_SA)) saFld <= regWrData[ADDR_W-1:FLD_LSB];
        if (regWrEn && enReg && idle && (regSel == SEL_EA)) eaFld <= regWrData[ADDR_W-1:FLD_LSB];
        case (state)
          ST_IDLE: begin
            if (startFire) begin
              scanCode   <= codeNext;
              scanBySect <= bySectNext;
              scanMask   <= allNext ? '1 : listAfter;
              allSect    <= 1'b0;
              endQ       <= 1'b0;
              errQ       <= 1'b0;
              state      <= bySectNext ? ST_SEL : ST_ISSUE;
            end
          end
          ST_SEL: begin
            if (scanMask == '0) begin
              state <= ST_IDLE;
              endQ  <= 1'b1;
            end else begin
              scanMask[secIdx] <= 1'b0;
              state            <= ST_ISSUE;
            end
          end
          ST_ISSUE: state <= ST_WAIT;
          ST_WAIT: begin
            if (rspValid) begin
              if (rspProt) errQ <= 1'b1;
              if (burstEnd && segEnd) begin
                if (scanBySect) begin
                  state <= ST_SEL;
                end else begin
                  state <= ST_IDLE;
                  endQ  <= 1'b1;
                end
              end else begin
                state <= ST_ISSUE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R8: never a second request while one is outstanding
  assert_one_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R8: the end flag rises only as a scan finishes
  assert_end_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(endFlag) |-> (!busy && $past(busy)));

  // R11: a disabled block is idle with an empty list
  assert_disabled_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !enReg |-> (!busy && (sectList == '0)));

  // R12: configuration is frozen during a scan
  assert_cfg_frozen_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !disableNow) |=> ($stable(saFld) && $stable(sectList) && $stable(scanCode)));

endmodule

// File: rtl/crc_burst_scanner.sv
module crc_burst_scanner
  import crc_scan_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int FLD_LSB      = 6,
  parameter int SECT_CNT     = 4,
  parameter int SECT_AW      = 15,
  parameter int WORD_W       = 128,
  parameter int RES_W        = 32,
  parameter int MIN_BURST_LG = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [31:0]       regWrData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              rspValid,
  input  logic [WORD_W-1:0] rspData,
  input  logic              rspProt,
  output logic              stepValid,
  output logic [WORD_W-1:0] stepWord,
  output logic              busy,
  output logic              endFlag,
  output logic              errFlag,
  output logic [RES_W-1:0]  result
);

  dpStrobe_t         strb;
  logic [ADDR_W-1:0] segBase;
  logic [ADDR_W-1:0] segLast;
  logic [1:0]        scanCode;
  logic              burstEnd;
  logic              segEnd;

  crc_scan_ctrl #(
    .ADDR_W(ADDR_W), .FLD_LSB(FLD_LSB), .SECT_CNT(SECT_CNT),
    .SECT_AW(SECT_AW), .MIN_BURST_LG(MIN_BURST_LG)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .rspValid(rspValid), .rspProt(rspProt),
    .burstEnd(burstEnd), .segEnd(segEnd),
    .strb(strb), .segBase(segBase), .segLast(segLast), .scanCode(scanCode),
    .memReq(memReq), .busy(busy), .endFlag(endFlag), .errFlag(errFlag)
  );

  crc_scan_dp #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .RES_W(RES_W), .MIN_BURST_LG(MIN_BURST_LG)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .strb(strb), .segBase(segBase), .segLast(segLast), .scanCode(scanCode),
    .rspData(rspData),
    .memAddr(memAddr), .burstEnd(burstEnd), .segEnd(segEnd),
    .result(result), .stepValid(stepValid), .stepWord(stepWord)
  );

endmodule

// File: tb/crc_burst_scanner_tb.sv
`timescale 1ns/1ps
module crc_burst_scanner_tb;

  localparam int ADR = 17;
  localparam logic [31:0] B_ADD = 32'h1, B_CLEAN = 32'h2, B_BYSECT = 32'h4,
    B_ALL = 32'h20, B_START = 32'h40, B_CLRRES = 32'h80, B_CLRFLG = 32'h100;

  // {code[35:34], start[33:17], end[16:0]}
  localparam logic [35:0] VEC [4] = '{
    {2'd0, 17'h00040, 17'h000C0},
    {2'd1, 17'h00140, 17'h00300},
    {2'd2, 17'h00800, 17'h00400},
    {2'd3, 17'h01FC0, 17'h03000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regSel = '0;
  logic [31:0] regWrData = '0;
  logic memReq;
  logic [ADR-1:0] memAddr;
  logic rspValid = 1'b0;
  logic [127:0] rspData = '0;
  logic rspProt = 1'b0;
  logic stepValid;
  logic [127:0] stepWord;
  logic busy, endFlag, errFlag;
  logic [31:0] result;

  int checks = 0;
  int fails = 0;
  int totalReads = 0;
  int markCnt = 0;
  logic [31:0] firstAddr = '0;
  logic [31:0] lastAddr = '0;

  always #4 clk = ~clk;

  crc_burst_scanner u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .memReq(memReq), .memAddr(memAddr), .rspValid(rspValid), .rspData(rspData),
    .rspProt(rspProt), .stepValid(stepValid), .stepWord(stepWord), .busy(busy),
    .endFlag(endFlag), .errFlag(errFlag), .result(result)
  );

  function automatic logic [127:0] wordAt(input logic [31:0] a);
    return {a * 32'h9E3779B1, ~a ^ 32'h5A5A0000, (a << 8) ^ 32'hA5A50000, a + 32'h01000000};
  endfunction

  function automatic logic isProt(input logic [31:0] a);
    return (a >= 32'h1000) && (a < 32'h1040);
  endfunction

  function automatic logic [31:0] foldIn(input logic [31:0] r, input logic [31:0] a);
    logic [127:0] w = wordAt(a);
    return {r[30:0], r[31]} ^ w[31:0] ^ w[63:32] ^ w[95:64] ^ w[127:96];
  endfunction

  // memory model: one-cycle response
  always @(posedge clk) begin
    rspValid <= memReq;
    rspData  <= wordAt(32'(memAddr));
    rspProt  <= isProt(32'(memAddr));
    if (memReq) begin
      if (totalReads == markCnt) firstAddr = 32'(memAddr);
      lastAddr = 32'(memAddr);
      totalReads = totalReads + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic waitEnd(output int n);
    n = 0;
    while (!endFlag && n < 40000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic runScan(input logic [31:0] d, output int n);
    markCnt = totalReads;
    wr(2'd1, d | B_START);
    waitEnd(n);
  endtask

  task automatic modelRange(input logic [1:0] code, input logic [31:0] s, input logic [31:0] e,
                            inout logic [31:0] r, output int cnt, output logic [31:0] f,
                            output logic [31:0] l, output logic err);
    logic [31:0] bb = 32'd64 << (2 * code);
    logic [31:0] b0 = (s & 32'h1FFC0) & ~(bb - 1);
    logic [31:0] b1 = (e & 32'h1FFC0) & ~(bb - 1);
    if (b1 < b0) b1 = b0;
    cnt = 0; err = 1'b0; f = b0; l = b1 + bb - 16;
    for (logic [31:0] a = b0; a < b1 + bb; a += 16) begin
      cnt++;
      if (isProt(a)) err = 1'b1;
      else r = foldIn(r, a);
    end
  endtask

  task automatic modelSect(input logic [3:0] mask, inout logic [31:0] r);
    for (int s = 0; s < 4; s++) begin
      if (mask[s]) begin
        for (int a = s * 32768; a < (s + 1) * 32768; a += 16) begin
          if (!isProt(32'(a))) r = foldIn(r, 32'(a));
        end
      end
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int n, cnt, r0;
    logic [31:0] er, ef, el;
    logic ee;

    repeat (3) @(negedge clk);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 endFlag", 32'(endFlag), 0);
    chk("R1 errFlag", 32'(errFlag), 0);
    chk("R1 memReq", 32'(memReq), 0);
    chk("R1 result", result, 0);
    rstN = 1'b1;
    wr(2'd0, 32'h1);

    // R2 R3 R9: range scans from the vector table
    for (int v = 0; v < 4; v++) begin
      logic [1:0] code = VEC[v][35:34];
      logic [31:0] s = 32'(VEC[v][33:17]);
      logic [31:0] e = 32'(VEC[v][16:0]);
      wr(2'd1, B_CLRRES | (32'(code) << 3));
      wr(2'd2, s);
      wr(2'd3, e);
      er = '0;
      modelRange(code, s, e, er, cnt, ef, el, ee);
      runScan(32'(code) << 3, n);
      chk($sformatf("R3 vec%0d reads", v), 32'(totalReads - markCnt), 32'(cnt));
      chk($sformatf("R2 vec%0d first", v), firstAddr, ef);
      chk($sformatf("R2 vec%0d last", v), lastAddr, el);
      chk($sformatf("R9 vec%0d result", v), result, er);
      chk($sformatf("R9 vec%0d errFlag", v), 32'(errFlag), 32'(ee));
      chk($sformatf("R8 vec%0d endFlag", v), 32'(endFlag), 1);
    end

    // R8: clear flags
    wr(2'd1, B_CLRFLG);
    chk("R8 endFlag cleared", 32'(endFlag), 0);
    chk("R8 errFlag cleared", 32'(errFlag), 0);

    // R4: sectors 2 and 0 listed, scanned ascending
    wr(2'd1, B_CLEAN | B_BYSECT | (32'd3 << 3) | B_CLRRES);
    wr(2'd1, B_ADD | (32'd2 << 16) | B_BYSECT | (32'd3 << 3));
    wr(2'd1, B_ADD | B_BYSECT | (32'd3 << 3));
    markCnt = totalReads;
    wr(2'd1, B_BYSECT | (32'd3 << 3) | B_START);
    chk("R8 busy after start", 32'(busy), 1);
    waitEnd(n);
    er = '0; modelSect(4'b0101, er);
    chk("R4 sector reads", 32'(totalReads - markCnt), 4096);
    chk("R4 sector first", firstAddr, 32'h0);
    chk("R4 sector last", lastAddr, 32'h17FF0);
    chk("R4 sector order result", result, er);
    chk("R9 sector errFlag", 32'(errFlag), 1);

    // R5: clean and add in one write with start
    wr(2'd1, B_CLRRES | B_BYSECT);
    runScan(B_CLEAN | B_ADD | (32'd1 << 16) | B_BYSECT, n);
    chk("R5 reads", 32'(totalReads - markCnt), 2048);
    chk("R5 first", firstAddr, 32'h8000);
    chk("R5 last", lastAddr, 32'hFFF0);

    // R6: all sectors, then self-cleared
    runScan(B_ALL | B_BYSECT | B_CLRRES, n);
    er = '0; modelSect(4'b1111, er);
    chk("R6 all reads", 32'(totalReads - markCnt), 8192);
    chk("R6 all result", result, er);
    runScan(B_BYSECT | B_CLRRES, n);
    chk("R6 self-clear reads", 32'(totalReads - markCnt), 2048);
    chk("R6 self-clear first", firstAddr, 32'h8000);

    // R4: empty list
    wr(2'd1, B_CLEAN | B_BYSECT);
    runScan(B_BYSECT, n);
    chk("R4 empty reads", 32'(totalReads - markCnt), 0);
    chk("R4 empty end latency", 32'(n), 1);

    // R7 R12: start and config while busy
    wr(2'd2, 32'h0);
    wr(2'd3, 32'h3000);
    markCnt = totalReads;
    wr(2'd1, (32'd3 << 3) | B_START);
    repeat (100) @(negedge clk);
    wr(2'd1, B_BYSECT | B_START);
    wr(2'd2, 32'h800);
    waitEnd(n);
    r0 = totalReads - markCnt;
    chk("R7 busy start ignored reads", 32'(r0), 1024);
    repeat (50) @(negedge clk);
    chk("R7 no extra scan", 32'(totalReads - markCnt), 1024);
    runScan(32'd3 << 3, n);
    chk("R12 start field kept", firstAddr, 32'h0);

    // R10: clear and fold in the same cycle
    wr(2'd3, 32'h40);
    wr(2'd1, B_CLRRES);
    markCnt = totalReads;
    wr(2'd1, B_START);
    n = 0;
    while (!(memReq && memAddr == 17'h20) && n < 1000) begin
      @(negedge clk); n++;
    end
    @(negedge clk);
    regWrEn = 1'b1; regSel = 2'd1; regWrData = B_CLRRES;
    @(negedge clk);
    regWrEn = 1'b0;
    waitEnd(n);
    er = '0;
    for (logic [31:0] a = 32'h30; a <= 32'h70; a += 16) er = foldIn(er, a);
    chk("R10 clear beats fold", result, er);

    // R11: disable mid-scan
    wr(2'd2, 32'h800);
    wr(2'd3, 32'h3000);
    wr(2'd1, B_ADD | (32'd1 << 16));
    markCnt = totalReads;
    wr(2'd1, (32'd3 << 3) | B_START);
    repeat (100) @(negedge clk);
    wr(2'd0, 32'h0);
    chk("R11 busy after disable", 32'(busy), 0);
    chk("R11 endFlag after abort", 32'(endFlag), 0);
    chk("R11 result cleared", result, 0);
    r0 = totalReads;
    repeat (20) @(negedge clk);
    chk("R11 reads stopped", 32'(totalReads - r0), 0);

    // R7 R12: ignored while disabled
    wr(2'd1, B_ADD | (32'd3 << 16) | B_BYSECT | B_START);
    chk("R7 start while disabled", 32'(busy), 0);
    wr(2'd0, 32'h1);
    runScan(32'h0, n);
    chk("R11 range reset reads", 32'(totalReads - markCnt), 4);
    chk("R11 range reset first", firstAddr, 32'h0);
    runScan(B_BYSECT, n);
    chk("R12 list untouched while disabled", 32'(totalReads - markCnt), 0);

    summary();
    $finish;
  end

endmodule